// File: doc/BRIEF.md
# Cross-Domain 64-Bit Counter Snapshot

This block keeps a 64-bit free-running count in a reference clock domain of roughly 24 MHz and lets software on an APB bus in an unrelated clock domain read that count safely. The bus never looks at the live counter. Software writes a request bit in the control register. The request crosses into the reference domain, where the whole count is frozen into a shadow register in a single reference cycle. An acknowledge returns to the bus domain, the bus-side holding registers load from the frozen shadow, and the request bit drops to zero. Once the bit reads zero, the low and high words read as one coherent 64-bit value.

A second control bit zeroes the counter through the same kind of request and acknowledge crossing. It reads as one until the reference domain has done the clear. Both requests are tracked by one bus-side state machine with four states: ST_IDLE (nothing pending), ST_SNAP (snapshot pending), ST_CLEAR (clear pending) and ST_BOTH (both pending). A write that sets a bit starts that operation: ST_IDLE goes to ST_SNAP, ST_CLEAR or ST_BOTH, ST_SNAP goes to ST_BOTH, and ST_CLEAR goes to ST_BOTH. The matching acknowledge ends it: ST_BOTH falls back to ST_SNAP or ST_CLEAR, and those fall back to ST_IDLE. When both acknowledges arrive in the same cycle, ST_BOTH goes straight to ST_IDLE.

Top module: `snap_counter64`

## Requirements
- R1: After the reference reset is released, the counter starts at the RESET_VAL parameter and advances by exactly one on every rising edge of `rclk`. Successive snapshots therefore strictly increase.
- R2: Writing a control word with bit 1 set (control at offset 0x0) starts a snapshot. Control bit 1 then reads 1 until the holding registers have loaded, and reads 0 from the cycle they load.
- R3: A completed snapshot holds a counter value no smaller than the count when the request was written and no larger than the count when bit 1 was seen clear. Offset 0x4 returns bits 31:0 of that value and offset 0x8 returns bits 63:32.
- R4: A snapshot or a clear completes within four reference-clock periods plus six bus-clock periods of its control write.
- R5: Outside a snapshot, the low and high words stay unchanged.
- R6: Writing bit 1 again while a snapshot is pending has no effect. Exactly one snapshot completes, and bit 1 stays 0 afterwards.
- R7: Writing 0 to the control register during a snapshot does not cancel it. Bit 1 still reads 1, and the snapshot completes with a valid value.
- R8: Writing a control word with bit 0 set zeroes the counter in the reference domain. Bit 0 reads 1 until the clear is done, and a later snapshot returns a value from 1 up to the number of reference edges since the clear was written.
- R9: The high and low words stay coherent when the count carries from bit 31 into bit 32. A snapshot taken after the carry reads 1 in the high word.
- R10: Every access completes with zero wait states (`pready` is always 1), and reads at offsets other than 0x0, 0x4 and 0x8 return zero.
- R11: After reset, the control, low and high registers all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low, asynchronous |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, combinational from the address |
| pready | output | 1 | Always 1 (no wait states) |
| rclk | input | 1 | Reference clock of about 24 MHz, asynchronous to pclk |
| rrst_n | input | 1 | Reference-domain reset, active low, asynchronous |

## Verification
A control write takes effect at the bus edge that ends its access phase. The request toggle then needs two reference edges to cross over, plus one more edge to freeze the shadow. The acknowledge needs two bus edges to return before the holding registers load and the busy bit drops. So a busy bit is due to clear no sooner than about two reference periods and no later than four reference periods plus a few bus cycles. The bench reads the busy bit within a few bus cycles of the write, when it must still be 1. It then polls and compares the measured delay against the R4 bound. Snapshot values are judged against a bench-side count of reference edges, taken just after the request write and again when the busy bit is seen clear. Data reads are sampled on the falling bus edge during the access phase, when `prdata` has settled.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;

    // register offsets and control bit positions
    localparam int OFF_CTRL  = 'h0;
    localparam int OFF_LO    = 'h4;
    localparam int OFF_HI    = 'h8;
    localparam int LATCH_BIT = 1;
    localparam int CLEAR_BIT = 0;

    // encoding: {snapshot pending, clear pending}
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_CLEAR = 2'b01,
        ST_SNAP  = 2'b10,
        ST_BOTH  = 2'b11
    } snap_state_e;

endpackage

// File: rtl/snap_sync.sv
`timescale 1ns/1ps
module snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/snap_ref_core.sv
`timescale 1ns/1ps
module snap_ref_core #(
    parameter int               CNT_W       = 64,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] RESET_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_req_tgl,
    input  logic             clr_req_tgl,
    output logic             snap_ack,
    output logic             clr_ack,
    output logic [CNT_W-1:0] shadow
);

    logic [CNT_W-1:0] cnt;
    logic snap_req_s, clr_req_s;
    logic snap_hit, clr_hit;

    snap_sync #(.STAGES(SYNC_STAGES)) u_snap_in (
        .clk(clk), .rst_n(rst_n), .d(snap_req_tgl), .q(snap_req_s));
    snap_sync #(.STAGES(SYNC_STAGES)) u_clr_in (
        .clk(clk), .rst_n(rst_n), .d(clr_req_tgl), .q(clr_req_s));

    // a new request shows up as a difference to the last seen level
    assign snap_hit = snap_req_s ^ snap_ack;
    assign clr_hit  = clr_req_s ^ clr_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= RESET_VAL;
            shadow   <= '0;
            snap_ack <= 1'b0;
            clr_ack  <= 1'b0;
        end else begin
            cnt      <= clr_hit ? '0 : cnt + CNT_W'(1);
            if (snap_hit) shadow <= cnt;
            snap_ack <= snap_req_s;
            clr_ack  <= clr_req_s;
        end
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> cnt == $past(cnt) + CNT_W'(1));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> cnt == '0);

    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_hit |=> $stable(shadow));

endmodule

// File: rtl/snap_bus_fsm.sv
`timescale 1ns/1ps
module snap_bus_fsm
    import snap_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             want_snap,
    input  logic             want_clr,
    input  logic             snap_ack_s,
    input  logic             clr_ack_s,
    input  logic [CNT_W-1:0] shadow,
    output logic             snap_req_tgl,
    output logic             clr_req_tgl,
    output logic             snap_busy,
    output logic             clr_busy,
    output logic [CNT_W-1:0] hold
);

    snap_state_e state, state_n;
    logic snap_go, clr_go, snap_done, clr_done, snap_next, clr_next;

    always_comb begin
        unique case (state)
            ST_IDLE:  {snap_busy, clr_busy} = 2'b00;
            ST_CLEAR: {snap_busy, clr_busy} = 2'b01;
            ST_SNAP:  {snap_busy, clr_busy} = 2'b10;
            ST_BOTH:  {snap_busy, clr_busy} = 2'b11;
        endcase
        snap_done = snap_busy && (snap_ack_s == snap_req_tgl);
        clr_done  = clr_busy  && (clr_ack_s  == clr_req_tgl);
        snap_go   = ctrl_wr && want_snap && !snap_busy;
        clr_go    = ctrl_wr && want_clr  && !clr_busy;
        snap_next = snap_go || (snap_busy && !snap_done);
        clr_next  = clr_go  || (clr_busy  && !clr_done);
        unique case ({snap_next, clr_next})
            2'b00: state_n = ST_IDLE;
            2'b01: state_n = ST_CLEAR;
            2'b10: state_n = ST_SNAP;
            2'b11: state_n = ST_BOTH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // outputs: request toggles and holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_req_tgl <= 1'b0;
            clr_req_tgl  <= 1'b0;
            hold         <= '0;
        end else begin
            if (snap_go)   snap_req_tgl <= ~snap_req_tgl;
            if (clr_go)    clr_req_tgl  <= ~clr_req_tgl;
            if (snap_done) hold         <= shadow;
        end
    end

    a_r2_load_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snap_busy) |-> hold == shadow);

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_busy |=> $stable(hold));

    a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_busy && ctrl_wr && want_snap) |=> $stable(snap_req_tgl));

    a_r7_no_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_busy && (snap_ack_s != snap_req_tgl)) |=> snap_busy);

    a_r8_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && (clr_ack_s != clr_req_tgl)) |=> clr_busy);

endmodule

// File: rtl/snap_counter64.sv
`timescale 1ns/1ps
module snap_counter64
    import snap_pkg::*;
#(
    parameter int                  DATA_W      = 32,
    parameter int                  ADDR_W      = 12,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [2*DATA_W-1:0] RESET_VAL   = '0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              rclk,
    input  logic              rrst_n
);

    localparam int CNT_W = 2 * DATA_W;

    logic             snap_req_tgl, clr_req_tgl;
    logic             snap_ack, clr_ack, snap_ack_s, clr_ack_s;
    logic             snap_busy, clr_busy, ctrl_wr;
    logic [CNT_W-1:0] shadow, hold;
    logic             unused_wdata;

    assign unused_wdata = ^pwdata;
    assign ctrl_wr = psel && penable && pwrite && (paddr == ADDR_W'(OFF_CTRL));
    assign pready  = 1'b1;

    snap_ref_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .RESET_VAL(RESET_VAL)) u_ref (
        .clk(rclk), .rst_n(rrst_n),
        .snap_req_tgl(snap_req_tgl), .clr_req_tgl(clr_req_tgl),
        .snap_ack(snap_ack), .clr_ack(clr_ack), .shadow(shadow));

    snap_sync #(.STAGES(SYNC_STAGES)) u_snap_back (
        .clk(pclk), .rst_n(presetn), .d(snap_ack), .q(snap_ack_s));
    snap_sync #(.STAGES(SYNC_STAGES)) u_clr_back (
        .clk(pclk), .rst_n(presetn), .d(clr_ack), .q(clr_ack_s));

    snap_bus_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(pclk), .rst_n(presetn), .ctrl_wr(ctrl_wr),
        .want_snap(pwdata[LATCH_BIT]), .want_clr(pwdata[CLEAR_BIT]),
        .snap_ack_s(snap_ack_s), .clr_ack_s(clr_ack_s), .shadow(shadow),
        .snap_req_tgl(snap_req_tgl), .clr_req_tgl(clr_req_tgl),
        .snap_busy(snap_busy), .clr_busy(clr_busy), .hold(hold));

    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFF_CTRL)) begin
            prdata[LATCH_BIT] = snap_busy;
            prdata[CLEAR_BIT] = clr_busy;
        end else if (paddr == ADDR_W'(OFF_LO)) begin
            prdata = hold[DATA_W-1:0];
        end else if (paddr == ADDR_W'(OFF_HI)) begin
            prdata = hold[CNT_W-1:DATA_W];
        end
    end

    a_r10_unmapped_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr != ADDR_W'(OFF_CTRL) && paddr != ADDR_W'(OFF_LO)
         && paddr != ADDR_W'(OFF_HI)) |-> prdata == '0);

endmodule

// File: tb/sim_snap_counter64.sv
`timescale 1ns/1ps
module sim_snap_counter64;

    localparam int          BP    = 4;
    localparam int          RP    = 42;
    localparam logic [63:0] START = 64'h0000_0000_FFFF_FF00;
    localparam int K_EXACT = 0, K_SNAP_LO = 1, K_SNAP_HI = 2, K_LAST_LO = 3;

    logic        pclk = 1'b0, rclk = 1'b0, presetn = 1'b0, rrst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;

    always #(BP/2) pclk = ~pclk;
    always #(RP/2) rclk = ~rclk;

    snap_counter64 #(.RESET_VAL(START)) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .rclk(rclk), .rrst_n(rrst_n));

    // independent count of reference edges since reset release
    logic [63:0] model;
    always @(posedge rclk or negedge rrst_n)
        if (!rrst_n) model <= START;
        else         model <= model + 64'd1;

    typedef struct {
        int          kind;
        logic [63:0] lo_b;
        logic [63:0] hi_b;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] stash_lo;
    logic [63:0] last_snap = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] lo, input logic [63:0] hi);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h..%0h", tag, act, lo, hi);
        end
    endtask

    // monitor: pops one expectation per checked read, sampled mid-cycle
    always @(negedge pclk) begin
        if (psel && penable && !pwrite && q.size() > 0) begin
            exp_t e;
            logic [63:0] v;
            e = q.pop_front();
            case (e.kind)
                K_EXACT:   check(prdata == e.lo_b[31:0], e.tag, 64'(prdata), e.lo_b, e.lo_b);
                K_SNAP_LO: stash_lo = prdata;
                K_SNAP_HI: begin
                    v = {prdata, stash_lo};
                    last_snap = v;
                    check(v >= e.lo_b && v <= e.hi_b, e.tag, v, e.lo_b, e.hi_b);
                end
                default:   check(prdata == last_snap[31:0], e.tag, 64'(prdata),
                                 64'(last_snap[31:0]), 64'(last_snap[31:0]));
            endcase
        end
    end

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(negedge pclk);
        d = prdata;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic push(input int k, input logic [63:0] lo, input logic [63:0] hi,
                        input string tag);
        exp_t e;
        e.kind = k; e.lo_b = lo; e.hi_b = hi; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic expect_word(input logic [11:0] a, input logic [31:0] v, input string tag);
        logic [31:0] d;
        push(K_EXACT, 64'(v), 64'(v), tag);
        apb_read(a, d);
    endtask

    // poll a control bit until zero; check the completion delay (R4)
    task automatic wait_bit_clear(input int bitpos, input realtime t0, input string tag);
        logic [31:0] d;
        for (int i = 0; i < 200; i++) begin
            apb_read(12'h0, d);
            if (!d[bitpos]) break;
        end
        check(!d[bitpos] && ($realtime - t0) <= real'(4*RP + 6*BP), tag,
              64'($rtoi($realtime - t0)), 64'd0, 64'(4*RP + 6*BP));
    endtask

    // mode 0 plain, 1 repeated request, 2 zero write during snapshot
    task automatic snapshot(input int mode, input bit after_clr, input logic [63:0] clr_mark,
                            input string tag);
        logic [63:0] m_w, m_d;
        logic [31:0] d;
        realtime     t0;
        apb_write(12'h0, 32'h2);
        t0  = $realtime;
        m_w = model;
        if (mode == 1) apb_write(12'h0, 32'h2);
        if (mode == 2) begin
            apb_write(12'h0, 32'h0);
            expect_word(12'h0, 32'h2, "R7 zero write leaves snapshot pending");
        end else begin
            expect_word(12'h0, 32'h2, "R2 latch bit reads one while pending");
        end
        wait_bit_clear(1, t0, "R4 snapshot completion delay");
        m_d = model;
        push(K_SNAP_LO, '0, '0, tag);
        apb_read(12'h4, d);
        if (after_clr) push(K_SNAP_HI, 64'd1, m_d - clr_mark, tag);
        else           push(K_SNAP_HI, m_w, m_d, tag);
        apb_read(12'h8, d);
    endtask

    initial begin
        logic [63:0] prev, mark;
        logic [31:0] d;
        realtime     t0;
        #100;
        rrst_n = 1'b1; presetn = 1'b1;
        expect_word(12'h0, 32'h0, "R11 control after reset");
        expect_word(12'h4, 32'h0, "R11 low word after reset");
        expect_word(12'h8, 32'h0, "R11 high word after reset");
        check(pready == 1'b1, "R10 pready", 64'(pready), 64'd1, 64'd1);

        snapshot(0, 1'b0, '0, "R3 snapshot in window");
        prev = last_snap;
        repeat (40) @(posedge pclk);
        push(K_LAST_LO, '0, '0, "R5 low word stable between snapshots");
        apb_read(12'h4, d);
        expect_word(12'h00C, 32'h0, "R10 unmapped 0xC");
        expect_word(12'h010, 32'h0, "R10 unmapped 0x10");

        snapshot(1, 1'b0, '0, "R6 repeated request single snapshot");
        expect_word(12'h0, 32'h0, "R6 latch bit stays clear");
        repeat (60) @(posedge pclk);
        expect_word(12'h0, 32'h0, "R6 latch bit still clear later");
        check(last_snap > prev, "R1 snapshots increase", last_snap, prev + 1, prev + 1);
        prev = last_snap;

        snapshot(2, 1'b0, '0, "R7 snapshot completes after zero write");
        check(last_snap > prev, "R1 snapshots increase", last_snap, prev + 1, prev + 1);

        wait (model > 64'h1_0000_0010);
        snapshot(0, 1'b0, '0, "R9 snapshot across carry");
        expect_word(12'h8, 32'h1, "R9 high word after carry");

        apb_write(12'h0, 32'h1);
        t0   = $realtime;
        mark = model;
        expect_word(12'h0, 32'h1, "R8 clear bit reads one while pending");
        wait_bit_clear(0, t0, "R4 clear completion delay");
        repeat (30) @(posedge pclk);
        snapshot(0, 1'b1, mark, "R8 snapshot after clear");
        expect_word(12'h0, 32'h0, "R2 control idle at end");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule